// File: doc/BRIEF.md
# STN Pixel Data Formatter

The formatter sits between a frame-memory word stream and the data pins of a passive-matrix (STN) panel driver. It accepts 32-bit words over a valid/ready handshake, splits each word into pixels of 1, 2, 4, 8 or 16 bits, and shifts the resulting bit stream onto a 4-bit or 8-bit pixel bus. Each transfer on that bus is marked by a one-cycle pixel enable. For the sub-byte depths, a byte-order control sets which end of the word holds the first pixel.

The block counts bus transfers against a programmed per-line value and pulses a line sync after the last transfer of each line. It counts lines against a programmed per-frame value and pulses a frame sync with the line sync that closes the frame. Software programs the per-line value as (width / bus width) − 1 for the sub-byte depths. For the 8 and 16 bpp colour modes it programs (3 × width / bus width) − 1, since each pixel then carries three colour components. The block itself only compares counts.

Top module: `stn_pix_fmt`

## Requirements
- R1: `depth_i` selects the pixel size: 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 4 = 16 bpp.
- R2: With `big_end_i` low, pixel k of a word is bits [k·b + b − 1 : k·b] (b = bits per pixel). The output stream carries pixel 0 first, and `pix_o[0]` of each transfer holds the earliest stream bit.
- R3: With `big_end_i` high at 1, 2 or 4 bpp, pixel k is instead taken from field (32/b − 1 − k), so pixel 0 comes from the most significant field.
- R4: At 8 and 16 bpp, `big_end_i` has no effect on the output.
- R5: `bus8_i` high selects an 8-bit bus (4 transfers per word). Low selects a 4-bit bus on `pix_o[3:0]` (8 transfers per word), with `pix_o[7:4]` held at zero.
- R6: `word_ready_o` is high only when no unshifted bits remain. A word is taken when valid and ready are both high, and its first transfer appears in the next cycle.
- R7: No transfer is issued while the formatter is empty. After the first word has been taken, any cycle that is empty with no valid word sets the sticky `underflow_o`.
- R8: `lsync_o` is a one-cycle pulse in the cycle after transfer number `line_last_i`+1 of a line. The transfer count then restarts at zero.
- R9: `frame_last_i` + 1 lines make a frame. `fsync_o` pulses together with the `lsync_o` that ends the last line of each frame.
- R10: While `rst_ni` is low, `pix_en_o`, `lsync_o`, `fsync_o` and `underflow_o` are low and `word_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| depth_i | input | 3 | Pixel depth code |
| big_end_i | input | 1 | Reverse pixel order for sub-byte depths |
| bus8_i | input | 1 | 1 = 8-bit bus, 0 = 4-bit bus |
| line_last_i | input | 12 | Transfers per line minus one |
| frame_last_i | input | 10 | Lines per frame minus one |
| word_i | input | 32 | Frame-memory word |
| word_valid_i | input | 1 | Word valid |
| word_ready_o | output | 1 | Word accepted when high with valid |
| pix_o | output | 8 | Pixel data bus |
| pix_en_o | output | 1 | Pixel transfer enable |
| lsync_o | output | 1 | Line sync pulse |
| fsync_o | output | 1 | Frame sync pulse |
| underflow_o | output | 1 | Sticky starvation flag |

## Verification
The bench drives one asymmetric word through every depth, order and bus-width mix. For each mix it compares the first and last transfers. A wrong field-reversal stride or a missing depth gate would show up as a swapped nibble or a reversed bit group at one of the two ends. The bench also sets big-endian order at 8 and 16 bpp, where a design that leaked the reversal would scramble the bytes.

Line timing is run once with lines that align to word boundaries. It is run again on the narrow bus with a line ending mid-word, where an off-by-one counter or a counter reset on word load would misplace the sync pulses. A run that lets the input starve checks that the data enable stays low and that the underflow flag latches.

// File: rtl/stn_pix_pkg.sv
package stn_pix_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    DEPTH_1  = 3'd0,
    DEPTH_2  = 3'd1,
    DEPTH_4  = 3'd2,
    DEPTH_8  = 3'd3,
    DEPTH_16 = 3'd4
  } depth_e;

  function automatic logic is_sub_byte(depth_e d);
    return (d == DEPTH_1) || (d == DEPTH_2) || (d == DEPTH_4);
  endfunction
endpackage

// File: rtl/stn_pix_reorder.sv
module stn_pix_reorder
  import stn_pix_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] word_i,
  input  depth_e       depth_i,
  input  logic         big_end_i,
  output logic [W-1:0] word_o
);
  // Field-reversed copies for 1, 2 and 4 bit pixels
  for (genvar g = 0; g < 3; g++) begin : g_dep
    localparam int B = 1 << g;
    localparam int K = W / B;
    logic [W-1:0] rev;
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign rev[i] = word_i[(K - 1 - i / B) * B + (i % B)];
    end
  end

  always_comb begin
    word_o = word_i;
    if (big_end_i && is_sub_byte(depth_i)) begin
      unique case (depth_i)
        DEPTH_1: word_o = g_dep[0].rev;
        DEPTH_2: word_o = g_dep[1].rev;
        default: word_o = g_dep[2].rev;
      endcase
    end
  end
endmodule

// File: rtl/stn_pix_shift.sv
module stn_pix_shift #(
  parameter int W        = 32,
  parameter int OUT_W    = 8,
  parameter int NARROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     word_i,
  input  logic             valid_i,
  input  logic             bus_wide_i,
  output logic             empty_o,
  output logic [OUT_W-1:0] pix_o,
  output logic             pix_en_o,
  output logic             underflow_o
);
  localparam int RW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [RW-1:0] rem_q;
  logic          started_q;
  logic [RW-1:0] step;

  assign step     = bus_wide_i ? RW'(OUT_W) : RW'(NARROW_W);
  assign empty_o  = (rem_q == '0);
  assign pix_en_o = !empty_o;

  always_comb begin
    pix_o = sh_q[OUT_W-1:0];
    if (!bus_wide_i) pix_o[OUT_W-1:NARROW_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      rem_q       <= '0;
      started_q   <= 1'b0;
      underflow_o <= 1'b0;
    end else if (empty_o) begin
      if (valid_i) begin
        sh_q      <= word_i;
        rem_q     <= RW'(W);
        started_q <= 1'b1;
      end else if (started_q) begin
        underflow_o <= 1'b1;
      end
    end else begin
      sh_q  <= sh_q >> step;
      rem_q <= (rem_q > step) ? rem_q - step : '0;
    end
  end
endmodule

// File: rtl/stn_pix_timing.sv
module stn_pix_timing #(
  parameter int LINE_W  = 12,
  parameter int FRAME_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               xfer_i,
  input  logic [LINE_W-1:0]  line_last_i,
  input  logic [FRAME_W-1:0] frame_last_i,
  output logic               lsync_o,
  output logic               fsync_o
);
  logic [LINE_W-1:0]  xcnt_q;
  logic [FRAME_W-1:0] lcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xcnt_q  <= '0;
      lcnt_q  <= '0;
      lsync_o <= 1'b0;
      fsync_o <= 1'b0;
    end else begin
      lsync_o <= 1'b0;
      fsync_o <= 1'b0;
      if (xfer_i) begin
        // >= keeps the counter bounded if the limit is lowered mid-line
        if (xcnt_q >= line_last_i) begin
          xcnt_q  <= '0;
          lsync_o <= 1'b1;
          if (lcnt_q >= frame_last_i) begin
            lcnt_q  <= '0;
            fsync_o <= 1'b1;
          end else begin
            lcnt_q <= lcnt_q + 1'b1;
          end
        end else begin
          xcnt_q <= xcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stn_pix_fmt.sv
module stn_pix_fmt
  import stn_pix_pkg::*;
#(
  parameter int W        = WORD_W,
  parameter int OUT_W    = 8,
  parameter int NARROW_W = 4,
  parameter int LINE_W   = 12,
  parameter int FRAME_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         depth_i,
  input  logic               big_end_i,
  input  logic               bus8_i,
  input  logic [LINE_W-1:0]  line_last_i,
  input  logic [FRAME_W-1:0] frame_last_i,
  input  logic [W-1:0]       word_i,
  input  logic               word_valid_i,
  output logic               word_ready_o,
  output logic [OUT_W-1:0]   pix_o,
  output logic               pix_en_o,
  output logic               lsync_o,
  output logic               fsync_o,
  output logic               underflow_o
);
  logic [W-1:0] ordered;
  depth_e       depth;

  assign depth = depth_e'(depth_i);

  stn_pix_reorder #(.W(W)) u_reorder (
    .word_i    (word_i),
    .depth_i   (depth),
    .big_end_i (big_end_i),
    .word_o    (ordered)
  );

  stn_pix_shift #(.W(W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_i      (ordered),
    .valid_i     (word_valid_i),
    .bus_wide_i  (bus8_i),
    .empty_o     (word_ready_o),
    .pix_o       (pix_o),
    .pix_en_o    (pix_en_o),
    .underflow_o (underflow_o)
  );

  stn_pix_timing #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_timing (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .xfer_i       (pix_en_o),
    .line_last_i  (line_last_i),
    .frame_last_i (frame_last_i),
    .lsync_o      (lsync_o),
    .fsync_o      (fsync_o)
  );
endmodule

// File: rtl/stn_pix_fmt_chk.sv
module stn_pix_fmt_chk #(
  parameter int OUT_W    = 8,
  parameter int NARROW_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus8_i,
  input logic             word_valid_i,
  input logic             word_ready_o,
  input logic [OUT_W-1:0] pix_o,
  input logic             pix_en_o,
  input logic             lsync_o,
  input logic             fsync_o,
  input logic             underflow_o
);
  // R5
  narrow_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && !bus8_i) |-> (pix_o[OUT_W-1:NARROW_W] == '0));

  // R6
  load_then_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o) |=> pix_en_o);

  // R8
  lsync_after_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsync_o |-> $past(pix_en_o));

  // R8
  lsync_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsync_o |=> !lsync_o);

  // R9
  fsync_with_lsync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> lsync_o);

  // R7
  underflow_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> $past(!word_valid_i && !pix_en_o));

  // R7
  underflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
endmodule

bind stn_pix_fmt stn_pix_fmt_chk #(.OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/tb_stn_pix_fmt.sv
`timescale 1ns/1ps
module tb_stn_pix_fmt;
  localparam logic [31:0] WORD = 32'hA1B2C3D4;
  localparam int NV = 12;
  // {depth, big_end, bus8, first transfer, last transfer}
  localparam logic [20:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b1, 8'hD4, 8'hA1},  // R2
    {3'd0, 1'b1, 1'b1, 8'h85, 8'h2B},  // R3
    {3'd0, 1'b1, 1'b0, 8'h05, 8'h02},  // R3 R5
    {3'd1, 1'b1, 1'b1, 8'h4A, 8'h17},  // R3
    {3'd1, 1'b1, 1'b0, 8'h0A, 8'h01},  // R3
    {3'd2, 1'b1, 1'b1, 8'h1A, 8'h4D},  // R3
    {3'd2, 1'b1, 1'b0, 8'h0A, 8'h04},  // R3
    {3'd2, 1'b0, 1'b0, 8'h04, 8'h0A},  // R2 R5
    {3'd3, 1'b1, 1'b1, 8'hD4, 8'hA1},  // R4
    {3'd4, 1'b1, 1'b0, 8'h04, 8'h0A},  // R4
    {3'd4, 1'b0, 1'b1, 8'hD4, 8'hA1},  // R1
    {3'd3, 1'b0, 1'b0, 8'h04, 8'h0A}   // R1
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  depth_i = '0;
  logic        big_end_i = 1'b0;
  logic        bus8_i = 1'b1;
  logic [11:0] line_last_i = 12'hFFF;
  logic [9:0]  frame_last_i = 10'h3FF;
  logic [31:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o, pix_en_o, lsync_o, fsync_o, underflow_o;
  logic [7:0]  pix_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  stn_pix_fmt dut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    word_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run_vec(input int v);
    logic [7:0] first, last;
    int n;
    logic stall_ok;
    do_reset();
    depth_i   = VEC[v][20:18];
    big_end_i = VEC[v][17];
    bus8_i    = VEC[v][16];
    n = bus8_i ? 4 : 8;
    first = '0; last = '0; stall_ok = 1'b1;
    word_i = WORD;
    word_valid_i = 1'b1;
    @(negedge clk_i);
    word_valid_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (!pix_en_o || word_ready_o) stall_ok = 1'b0;
      if (k == 0) first = pix_o;
      last = pix_o;
      @(negedge clk_i);
    end
    chk(first == VEC[v][15:8], $sformatf("R2/R3/R4 vec%0d first", v), first, VEC[v][15:8]);
    chk(last == VEC[v][7:0], $sformatf("R2/R3/R4 vec%0d last", v), last, VEC[v][7:0]);
    // R6: busy for exactly n transfers, ready low throughout
    chk(stall_ok && !pix_en_o, $sformatf("R6 vec%0d stream", v), pix_en_o, 0);
  endtask

  task automatic timing_run(input logic b8, input int lc, input int fl, input int total,
                            input int exp_l, input int exp_f);
    int xf, nl, nf;
    logic pos_ok;
    do_reset();
    depth_i = 3'd3; big_end_i = 1'b0; bus8_i = b8;
    line_last_i = 12'(lc); frame_last_i = 10'(fl);
    word_i = WORD; word_valid_i = 1'b1;
    xf = 0; nl = 0; nf = 0; pos_ok = 1'b1;
    for (int c = 0; c < 400 && xf < total + 2; c++) begin
      @(negedge clk_i);
      if (lsync_o) begin
        nl++;
        if (xf == 0 || xf % (lc + 1) != 0) pos_ok = 1'b0;
      end
      if (fsync_o && (nl % (fl + 1) != 0)) pos_ok = 1'b0;
      if (fsync_o) nf++;
      if (xf >= total) word_valid_i = 1'b0;
      if (pix_en_o) xf++;
    end
    word_valid_i = 1'b0;
    // total is a whole number of words so the stream stops on a boundary
    chk(pos_ok, "R8 R9 sync position", nl, exp_l);
    chk(nl == exp_l, "R8 line sync count", nl, exp_l);
    chk(nf == exp_f, "R9 frame sync count", nf, exp_f);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R10: state held in reset
    chk(!pix_en_o && !lsync_o && !fsync_o && !underflow_o && word_ready_o,
        "R10 reset outputs", {pix_en_o, lsync_o, fsync_o, underflow_o, word_ready_o}, 5'b00001);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R7: idle before the first word is not an underflow
    chk(!underflow_o && !pix_en_o, "R7 idle before first word", underflow_o, 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R7: starved after a word, no transfer and sticky flag
    @(negedge clk_i);
    chk(!pix_en_o, "R7 no transfer while empty", pix_en_o, 0);
    chk(underflow_o, "R7 underflow set", underflow_o, 1);
    repeat (3) @(negedge clk_i);
    chk(underflow_o && !pix_en_o, "R7 underflow sticky", underflow_o, 1);

    // R8 R9: lines aligned to words, 8-bit bus
    timing_run(1'b1, 3, 1, 32, 8, 4);
    // R8 R9: 12-transfer lines ending mid-word on the 4-bit bus
    timing_run(1'b0, 11, 1, 48, 4, 2);

    // R10: reset in mid-stream clears everything
    word_valid_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!pix_en_o && !lsync_o && !fsync_o && !underflow_o && word_ready_o,
        "R10 mid-stream reset", {pix_en_o, lsync_o, fsync_o, underflow_o, word_ready_o}, 5'b00001);
    word_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule